// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block holds a four-field alarm (minute, hour, day of month, weekday) and compares it against the running calendar time once per minute. Each alarm field carries an active-low enable in its top bit, so software can match on any subset of the fields. When every enabled field equals the current time on a minute-rollover strobe, a sticky alarm flag is set. The flag drives an active-low, level interrupt while the alarm interrupt enable is set.

The time fields (BCD) and the one-cycle minute strobe come from an external timekeeping counter. A host reaches the alarm fields, the flag and the interrupt enable through a byte-wide register port. Writes take effect on the clock edge, and reads are combinational from the address. The alarm resolves only to the minute. It holds no seconds, month or year.

Top module: `calendar_alarm_matcher`

## Requirements
- R1: After reset, the four alarm registers read 0x80, the control register at 0x00 and the status register at 0x01 read 0x00, and irq_no is 1.
- R2: The alarm registers at addresses 0x0A (minute), 0x0B (hour), 0x0C (day of month) and 0x0D (weekday) read back all 8 written bits. Address 0x00 keeps only bit 1, the interrupt enable. Address 0x01 reads the alarm flag in bit 3. All other bits read 0.
- R3: With a field's bit 7 at 0, that field takes part in the match. The compared bits are minute 6:0, hour 5:0, day 5:0 and weekday 2:0. The flag sets when all enabled fields equal the current time on a strobe cycle.
- R4: A field whose bit 7 is 1 is left out of the match, whatever its value.
- R5: With bit 7 set in all four alarm registers, the flag never sets.
- R6: The flag sets only in a cycle where min_tick_i is 1. A matching time without the strobe leaves it clear.
- R7: The flag is sticky. Writing 0 to bit 3 at address 0x01 clears it. Writing 1 there leaves it unchanged and never sets it.
- R8: If a set condition and a clearing write occur in the same cycle, the flag ends up set.
- R9: irq_no is 0 exactly while the flag and the interrupt enable (bit 1 at 0x00) are both 1.
- R10: Addresses outside 0x00, 0x01 and 0x0A to 0x0D read 0, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| cur_min_i | input | 7 | Current minute, BCD |
| cur_hour_i | input | 6 | Current hour, BCD |
| cur_date_i | input | 6 | Current day of month, BCD |
| cur_wday_i | input | 3 | Current weekday |
| min_tick_i | input | 1 | One-cycle minute-rollover strobe |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
The hardest case to reach is a set and a clear of the flag landing on the same clock edge. The flag must already be set, and then the strobe and the clearing write must be presented in one cycle. The stimulus first raises the flag with a matching strobe. Then, in a single cycle, it drives the strobe together with a write of zero to the status register. A second hard case is a match that holds without the strobe. For this, the stimulus keeps a matching time on the inputs over several idle cycles before it pulses the strobe.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int MIN_W      = 7;
  localparam int HOUR_W     = 6;
  localparam int DATE_W     = 6;
  localparam int WDAY_W     = 3;
  localparam int NUM_FIELDS = 4;
  localparam int EN_BIT     = DATA_W - 1;
  localparam int IE_BIT     = 1;
  localparam int FLAG_BIT   = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_ALM0 = 5'h0A;
  localparam logic [DATA_W-1:0] ALM_RST  = 8'h80;
  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] fields_t;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output fields_t           alm_o,
  output logic              ie_o,
  output logic              clr_o
);
  fields_t alm_q;
  logic    ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FIELDS; i++) alm_q[i] <= ALM_RST;
      ie_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == ADR_CTRL) ie_q <= wdata_i[IE_BIT];
      for (int i = 0; i < NUM_FIELDS; i++)
        if (addr_i == ADDR_W'(int'(ADR_ALM0) + i)) alm_q[i] <= wdata_i;
    end
  end

  assign clr_o = we_i && (addr_i == ADR_STAT) && !wdata_i[FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_CTRL) rdata_o[IE_BIT] = ie_q;
    if (addr_i == ADR_STAT) rdata_o[FLAG_BIT] = flag_i;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(int'(ADR_ALM0) + i)) rdata_o = alm_q[i];
  end

  assign alm_o = alm_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  fields_t alm_i,
  input  fields_t cur_i,
  output logic    hit_o
);
  logic [NUM_FIELDS-1:0] en, ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int W = (i == 0) ? MIN_W : (i == 1) ? HOUR_W :
                       (i == 2) ? DATE_W : WDAY_W;
    assign en[i] = ~alm_i[i][EN_BIT];
    assign ok[i] = ~en[i] | (alm_i[i][W-1:0] == cur_i[i][W-1:0]);
  end

  // at least one field must be enabled
  assign hit_o = (|en) & (&ok);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_o <= 1'b0;
    else if (tick_i && hit_i) flag_o <= 1'b1; // set beats clear
    else if (clr_i)           flag_o <= 1'b0;
  end
endmodule

// File: rtl/calendar_alarm_matcher.sv
module calendar_alarm_matcher
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [DATE_W-1:0] cur_date_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic              min_tick_i,
  output logic              irq_no
);
  fields_t alm, cur;
  logic    ie, clr, hit, flag_q;

  assign cur[0] = DATA_W'(cur_min_i);
  assign cur[1] = DATA_W'(cur_hour_i);
  assign cur[2] = DATA_W'(cur_date_i);
  assign cur[3] = DATA_W'(cur_wday_i);

  alarm_regfile u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .flag_i(flag_q), .rdata_o(reg_rdata_o),
    .alm_o(alm), .ie_o(ie), .clr_o(clr)
  );

  alarm_match u_match (.alm_i(alm), .cur_i(cur), .hit_o(hit));

  alarm_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(min_tick_i), .hit_i(hit),
    .clr_i(clr), .flag_o(flag_q)
  );

  assign irq_no = ~(flag_q & ie);
endmodule

// File: rtl/calendar_alarm_chk.sv
module calendar_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              flag_i,
  input logic              hit_i,
  input logic              ie_i,
  input logic              irq_ni,
  input fields_t           alm_i
);
  assert_set_only_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(tick_i));

  assert_clear_only_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(we_i && addr_i == ADR_STAT && !wdata_i[FLAG_BIT]));

  assert_all_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !flag_i && alm_i[0][EN_BIT] && alm_i[1][EN_BIT] &&
     alm_i[2][EN_BIT] && alm_i[3][EN_BIT]) |=> !flag_i);

  assert_set_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i) |=> flag_i);

  assert_irq_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && ie_i) |-> !irq_ni);

  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_i && ie_i) |-> irq_ni);
endmodule

bind calendar_alarm_matcher calendar_alarm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(min_tick_i), .we_i(reg_we_i),
  .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .flag_i(flag_q), .hit_i(hit),
  .ie_i(ie), .irq_ni(irq_no), .alm_i(alm)
);

// File: tb/sim_calendar_alarm_matcher.sv
module sim_calendar_alarm_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0] a_min, a_hour, a_date, a_wday;
    logic [6:0] c_min;
    logic [5:0] c_hour, c_date;
    logic [2:0] c_wday;
    logic       fire;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'h30, 8'h12, 8'h15, 8'h03, 7'h30, 6'h12, 6'h15, 3'd3, 1'b1},
    '{8'h30, 8'h12, 8'h15, 8'h03, 7'h31, 6'h12, 6'h15, 3'd3, 1'b0},
    '{8'hB0, 8'h12, 8'h15, 8'h03, 7'h45, 6'h12, 6'h15, 3'd3, 1'b1},
    '{8'h05, 8'h80, 8'h80, 8'h80, 7'h05, 6'h07, 6'h21, 3'd1, 1'b1},
    '{8'h05, 8'h80, 8'h80, 8'h80, 7'h06, 6'h07, 6'h21, 3'd1, 1'b0},
    '{8'h80, 8'h23, 8'h80, 8'h80, 7'h00, 6'h22, 6'h01, 3'd0, 1'b0},
    '{8'h80, 8'h80, 8'h31, 8'h80, 7'h59, 6'h23, 6'h31, 3'd4, 1'b1},
    '{8'h80, 8'h80, 8'h80, 8'h06, 7'h10, 6'h10, 6'h10, 3'd6, 1'b1},
    '{8'h80, 8'h80, 8'h80, 8'h06, 7'h10, 6'h10, 6'h10, 3'd5, 1'b0},
    '{8'h80, 8'h80, 8'h80, 8'h80, 7'h00, 6'h00, 6'h01, 3'd0, 1'b0}
  };

  logic       clk = 0, rst_n = 0;
  logic [4:0] addr = '0;
  logic       we = 0, tick = 0;
  logic [7:0] wdata = '0, rdata;
  logic [6:0] cmin = '0;
  logic [5:0] chour = '0, cdate = '0;
  logic [2:0] cwday = '0;
  logic       irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_alarm_matcher u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cur_min_i(cmin),
    .cur_hour_i(chour), .cur_date_i(cdate), .cur_wday_i(cwday),
    .min_tick_i(tick), .irq_no(irq_n)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(5'(8'h0A + i), d); check("R1 alarm reg reset", d, 8'h80);
    end
    rd(5'h00, d); check("R1 ctrl reset", d, 8'h00);
    rd(5'h01, d); check("R1 status reset", d, 8'h00);
    check("R1 irq reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1;

    // R2 register access
    wr(5'h0A, 8'h59); rd(5'h0A, d); check("R2 alarm readback", d, 8'h59);
    wr(5'h0D, 8'hC7); rd(5'h0D, d); check("R2 alarm readback full", d, 8'hC7);
    wr(5'h00, 8'hFF); rd(5'h00, d); check("R2 ctrl only bit1", d, 8'h02);
    wr(5'h00, 8'h00);
    // R7 writing 1 to flag does not set it
    wr(5'h01, 8'hFF); rd(5'h01, d); check("R7 write one no set", d, 8'h00);
    // R10 unmapped address
    wr(5'h05, 8'hFF); rd(5'h05, d); check("R10 unmapped read", d, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(5'(8'h0A + i), d); check("R10 no side effect", d, (i == 0) ? 8'h59 : (i == 3) ? 8'hC7 : 8'h80);
    end

    // R3 R4 R5 vector walk
    foreach (VEC[k]) begin
      wr(5'h0A, VEC[k].a_min); wr(5'h0B, VEC[k].a_hour);
      wr(5'h0C, VEC[k].a_date); wr(5'h0D, VEC[k].a_wday);
      wr(5'h01, 8'h00);
      cmin = VEC[k].c_min; chour = VEC[k].c_hour;
      cdate = VEC[k].c_date; cwday = VEC[k].c_wday;
      pulse_tick();
      rd(5'h01, d);
      check($sformatf("R3/R4/R5 vector %0d", k), d, {4'd0, VEC[k].fire, 3'd0});
    end

    // R6 match held without strobe
    wr(5'h0A, 8'h30); wr(5'h0B, 8'h12); wr(5'h0C, 8'h15); wr(5'h0D, 8'h03);
    wr(5'h01, 8'h00);
    cmin = 7'h30; chour = 6'h12; cdate = 6'h15; cwday = 3'd3;
    repeat (5) @(negedge clk);
    rd(5'h01, d); check("R6 no tick no flag", d, 8'h00);
    pulse_tick();
    rd(5'h01, d); check("R6 tick sets flag", d, 8'h08);

    // R7 sticky
    cmin = 7'h31; pulse_tick();
    rd(5'h01, d); check("R7 sticky over mismatch", d, 8'h08);
    wr(5'h01, 8'h08); rd(5'h01, d); check("R7 write one keeps", d, 8'h08);

    // R9 interrupt gating
    check("R9 irq off with ie 0", {7'd0, irq_n}, 8'h01);
    wr(5'h00, 8'h02); #1;
    check("R9 irq on", {7'd0, irq_n}, 8'h00);
    wr(5'h01, 8'h00); #1;
    rd(5'h01, d); check("R7 write zero clears", d, 8'h00);
    check("R9 irq off after clear", {7'd0, irq_n}, 8'h01);

    // R8 set and clear in same cycle
    cmin = 7'h30; pulse_tick();
    rd(5'h01, d); check("R8 flag up before race", d, 8'h08);
    @(negedge clk); tick = 1; addr = 5'h01; wdata = 8'h00; we = 1;
    @(negedge clk); tick = 0; we = 0;
    rd(5'h01, d); check("R8 set wins", d, 8'h08);
    check("R9 irq on after race", {7'd0, irq_n}, 8'h00);

    // R5 all fields disabled, no fire even with matching values
    wr(5'h01, 8'h00);
    wr(5'h0A, 8'hB0); wr(5'h0B, 8'h92); wr(5'h0C, 8'h95); wr(5'h0D, 8'h83);
    pulse_tick();
    rd(5'h01, d); check("R5 all disabled", d, 8'h00);
    check("R9 irq idle", {7'd0, irq_n}, 8'h01);

    finish_run();
  end
endmodule